// File: doc/BRIEF.md
# Physical Register Renamer with FIFO Free Pool

This block gives each instruction of an in-order stream new names for its registers. One instruction per cycle can be offered. Each one names two source registers and may name one destination. The second source may instead carry an immediate field. The block looks up the physical tags of the sources in an architectural-to-physical map. When the instruction writes a destination, the block also takes a fresh physical tag from a first-in-first-out pool of unused tags and points the destination's map entry at it.

Lookup and allocation happen in the cycle an instruction is accepted. The renamed fields appear on registered outputs one cycle later. A separate release port puts a freed physical tag back at the tail of the pool. When the pool is empty, an instruction that needs a destination is held back, and the block changes nothing until a tag comes back. An instruction without a destination still passes when the pool is empty.

Top module: `phys_renamer`

## Requirements
- R1: After reset, architectural register i maps to physical register i for every i below NUM_ARCH (default 8).
- R2: After reset the pool holds physical tags NUM_ARCH to NUM_PHYS-1 (defaults 8 to 15). Successive allocations hand them out in ascending order.
- R3: An accepted instruction with `in_has_dst`=1 receives the tag at the head of the pool on `out_dst`. From then on, every source read of that destination returns this tag until the destination is written again.
- R4: Sources are translated through the map as it stood before the same instruction's destination update. A source equal to the destination gets the previous mapping.
- R5: When `in_src2_imm`=1, `out_src2` carries `in_src2` zero-extended and untranslated, and `out_src2_imm` is 1.
- R6: When the pool is empty and `in_has_dst`=1, `in_ready` is 0 and `stall` follows `in_valid`. The map and the pool keep their contents and `out_valid` stays 0.
- R7: An instruction with `in_has_dst`=0 is accepted even when the pool is empty, and it consumes no tag.
- R8: A tag presented with `rel_valid`=1 joins the tail of the pool. Tags are handed out in the order they were returned. The pool holds at most NUM_PHYS-NUM_ARCH tags.
- R9: `out_valid` is 1 exactly in the cycle after an instruction is accepted (`in_valid` and `in_ready` both 1), and is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Instruction can be taken this cycle |
| in_src1 | input | AW | First source architectural register |
| in_src2 | input | AW | Second source register, or immediate field |
| in_src2_imm | input | 1 | Second source is an immediate |
| in_has_dst | input | 1 | Instruction writes a destination |
| in_dst | input | AW | Destination architectural register |
| rel_valid | input | 1 | Return a freed tag to the pool |
| rel_tag | input | PW | Tag being returned |
| stall | output | 1 | Offered instruction held for lack of a free tag |
| out_valid | output | 1 | Renamed instruction present |
| out_src1 | output | PW | Physical tag of first source |
| out_src2 | output | PW | Physical tag of second source, or immediate passed through |
| out_src2_imm | output | 1 | Echo of the immediate flag |
| out_has_dst | output | 1 | Echo of the destination flag |
| out_dst | output | PW | Newly allocated destination tag |

## Verification
The stream starts with source-only reads of every register, which show the identity map without using the pool. Next come instructions whose sources equal their destination, which separate the mapping before the update from the mapping after it. A drain of the whole pool follows. Offers made while the pool is empty separate the held case with a destination from the accepted case without one. Returning tags in a chosen order shows that the pool is first-in-first-out and not a stack. A long random mix then follows, with immediates, releases of old tags and stalls. A behavioural model built from queues compares it on every cycle.

// File: rtl/phys_renamer.sv
module phys_renamer #(
  parameter int NUM_ARCH = 8,
  parameter int NUM_PHYS = 16,
  localparam int AW    = $clog2(NUM_ARCH),
  localparam int PW    = $clog2(NUM_PHYS),
  localparam int DEPTH = NUM_PHYS - NUM_ARCH,
  localparam int QW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [AW-1:0] in_src1,
  input  logic [AW-1:0] in_src2,
  input  logic          in_src2_imm,
  input  logic          in_has_dst,
  input  logic [AW-1:0] in_dst,
  input  logic          rel_valid,
  input  logic [PW-1:0] rel_tag,
  output logic          stall,
  output logic          out_valid,
  output logic [PW-1:0] out_src1,
  output logic [PW-1:0] out_src2,
  output logic          out_src2_imm,
  output logic          out_has_dst,
  output logic [PW-1:0] out_dst
);

  logic [PW-1:0] map_q  [NUM_ARCH];
  logic [PW-1:0] pool_q [DEPTH];
  logic [QW-1:0] head_q, tail_q;
  logic [CW-1:0] cnt_q;

  logic accept, alloc, pool_empty;

  assign pool_empty = (cnt_q == '0);
  assign in_ready   = !(in_has_dst && pool_empty);
  assign stall      = in_valid && !in_ready;
  assign accept     = in_valid && in_ready;
  assign alloc      = accept && in_has_dst;

  function automatic logic [QW-1:0] bump(input logic [QW-1:0] p);
    return (p == QW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_ARCH; i++) map_q[i] <= PW'(i);
      for (int i = 0; i < DEPTH; i++) pool_q[i] <= PW'(NUM_ARCH + i);
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= CW'(DEPTH);
    end else begin
      if (alloc) begin
        map_q[in_dst] <= pool_q[head_q];
        head_q        <= bump(head_q);
      end
      if (rel_valid) begin
        pool_q[tail_q] <= rel_tag;
        tail_q         <= bump(tail_q);
      end
      cnt_q <= cnt_q + CW'(rel_valid) - CW'(alloc);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_src1     <= '0;
      out_src2     <= '0;
      out_src2_imm <= 1'b0;
      out_has_dst  <= 1'b0;
      out_dst      <= '0;
    end else begin
      out_valid <= accept;
      if (accept) begin
        out_src1     <= map_q[in_src1];
        out_src2     <= in_src2_imm ? PW'(in_src2) : map_q[in_src2];
        out_src2_imm <= in_src2_imm;
        out_has_dst  <= in_has_dst;
        out_dst      <= in_has_dst ? pool_q[head_q] : '0;
      end
    end
  end

  // R9
  accept_to_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);
  // R9
  idle_no_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> !out_valid);
  // R6
  empty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_has_dst && pool_empty) |-> (stall && !in_ready));
  // R6
  stall_keeps_pool_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !rel_valid) |=> ($stable(cnt_q) && $stable(head_q)));
  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rel_valid |-> (cnt_q < CW'(DEPTH) || alloc));
  // R5
  imm_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_src2_imm) |=> (out_src2 == PW'($past(in_src2)) && out_src2_imm));
  // R7
  no_dst_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_has_dst) |-> in_ready);

endmodule

// File: tb/tb_phys_renamer.sv
`timescale 1ns/1ps
module tb_phys_renamer;
  localparam int NA = 8;
  localparam int NP = 16;
  localparam int AW = $clog2(NA);
  localparam int PW = $clog2(NP);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_src2_imm = 1'b0, in_has_dst = 1'b0, rel_valid = 1'b0;
  logic [AW-1:0] in_src1 = '0, in_src2 = '0, in_dst = '0;
  logic [PW-1:0] rel_tag = '0;
  logic in_ready, stall, out_valid, out_src2_imm, out_has_dst;
  logic [PW-1:0] out_src1, out_src2, out_dst;

  always #2.5 clk = ~clk;

  phys_renamer #(.NUM_ARCH(NA), .NUM_PHYS(NP)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_src1(in_src1), .in_src2(in_src2), .in_src2_imm(in_src2_imm),
    .in_has_dst(in_has_dst), .in_dst(in_dst), .rel_valid(rel_valid),
    .rel_tag(rel_tag), .stall(stall), .out_valid(out_valid),
    .out_src1(out_src1), .out_src2(out_src2), .out_src2_imm(out_src2_imm),
    .out_has_dst(out_has_dst), .out_dst(out_dst));

  int checks = 0;
  int errors = 0;
  int map_m [NA];
  int fq [$];
  int pool [$];

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic step(bit v, int s1, int s2, bit imm, bit hd, int d,
                      bit rv, int rt, string req);
    bit exp_rdy, acc;
    int e1, e2, ed;
    @(negedge clk);
    in_valid = v; in_src1 = AW'(s1); in_src2 = AW'(s2); in_src2_imm = imm;
    in_has_dst = hd; in_dst = AW'(d); rel_valid = rv; rel_tag = PW'(rt);
    #1;
    exp_rdy = !(hd && fq.size() == 0);
    chk(in_ready == exp_rdy, req, "in_ready", int'(in_ready), int'(exp_rdy));
    chk(stall == (v && !exp_rdy), req, "stall", int'(stall), int'(v && !exp_rdy));
    acc = v && exp_rdy;
    e1 = 0; e2 = 0; ed = 0;
    if (acc) begin
      e1 = map_m[s1];
      e2 = imm ? s2 : map_m[s2];
      if (hd) begin
        ed = fq.pop_front();
        pool.push_back(map_m[d]);
        map_m[d] = ed;
      end
    end
    if (rv) fq.push_back(rt);
    @(posedge clk);
    #1;
    in_valid = 1'b0; rel_valid = 1'b0;
    chk(out_valid == acc, "R9", "out_valid", int'(out_valid), int'(acc));
    if (acc) begin
      chk(int'(out_src1) == e1, req, "out_src1", int'(out_src1), e1);
      chk(int'(out_src2) == e2, req, "out_src2", int'(out_src2), e2);
      chk(out_src2_imm == imm, "R5", "out_src2_imm", int'(out_src2_imm), int'(imm));
      chk(out_has_dst == hd, req, "out_has_dst", int'(out_has_dst), int'(hd));
      if (hd) chk(int'(out_dst) == ed, req, "out_dst", int'(out_dst), ed);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    int t;
    for (int i = 0; i < NA; i++) map_m[i] = i;
    for (int i = NA; i < NP; i++) fq.push_back(i);
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R9", "out_valid after reset", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);

    // R1: identity map, source-only
    for (int i = 0; i < NA; i++) step(1, i, NA - 1 - i, 0, 0, 0, 0, 0, "R1");
    // R4: source equals destination gets old tag; R2 first tag is NA
    step(1, 3, 3, 0, 1, 3, 0, 0, "R4");
    // R3: later reader sees new tag
    step(1, 3, 0, 0, 0, 0, 0, 0, "R3");
    // R5: immediate passthrough
    step(1, 3, 6, 1, 0, 0, 0, 0, "R5");
    // R2: drain pool in ascending order
    for (int i = 0; i < NP - NA - 1; i++) step(1, i % NA, 3, 0, 1, i % NA, 0, 0, "R2");
    // R6: empty pool holds a destination instruction
    step(1, 1, 2, 0, 1, 5, 0, 0, "R6");
    step(1, 1, 2, 0, 1, 5, 0, 0, "R6");
    // R7: no-destination instruction passes with empty pool
    step(1, 5, 1, 0, 0, 0, 0, 0, "R7");
    // R8: return two tags, they come back in return order
    t = pool.pop_front();
    step(0, 0, 0, 0, 0, 0, 1, t, "R8");
    t = pool.pop_front();
    step(1, 1, 2, 0, 1, 5, 1, t, "R6");
    step(1, 5, 5, 0, 1, 5, 0, 0, "R8");
    step(1, 5, 2, 0, 1, 2, 0, 0, "R8");
    // random mix
    for (int n = 0; n < 400; n++) begin
      bit rv;
      int rt;
      rv = (pool.size() != 0) && ($urandom_range(0, 9) < 4);
      rt = rv ? pool.pop_front() : 0;
      step($urandom_range(0, 9) < 8, $urandom_range(0, NA - 1), $urandom_range(0, NA - 1),
           $urandom_range(0, 3) == 0, $urandom_range(0, 9) < 7, $urandom_range(0, NA - 1),
           rv, rt, "R3");
    end
    summary();
  end
endmodule